// File: doc/BRIEF.md
# Vectored IRQ Entry Port

This block sits on the processor side of the link to an external vectored interrupt controller. Two active-low request lines come in, one for fast interrupts and one for normal interrupts. Each passes through a two-flop synchronizer, or through a direct path when its bypass input is HIGH, and reaches the core as an active-high pending flag.

When the core begins an interrupt entry, the block returns the branch target, marked by a one-cycle ready strobe. A fast-interrupt entry always gets the fixed vector. A normal-interrupt entry gets the legacy vector when the vector port is disabled. When the vector port is enabled, the block runs a four-phase handshake with the controller to fetch the vector:

1. The block raises an acknowledge.
2. It waits for the address-valid input to read HIGH after synchronization, then captures the word address.
3. It drops the acknowledge.
4. It waits for valid to fall before it accepts another entry.

The valid input has its own two-flop synchronizer and its own bypass. This lets the controller run on the core clock or on an unrelated clock.

Top module: `irq_vector_port`

## Requirements
- R1: `fiq_req_n` and `irq_req_n` are active LOW. `fiq_pending` and `irq_pending` are HIGH when their input is LOW, and LOW when it is HIGH.
- R2: When `req_sync_bypass` is LOW, a change on a request input reaches its pending output after two rising clock edges. When it is HIGH, the change appears in the same cycle, with no clock edge.
- R3: `vld_sync_bypass` applies only to `vec_valid`. When it is LOW, the handshake sees `vec_valid` two edges late. When it is HIGH, the handshake sees `vec_valid` at once. In both cases the request paths are unaffected.
- R4: The block may be idle with `vec_port_en` HIGH and an IRQ entry started (without an FIQ entry in the same cycle). Then `vec_ack` rises on the next edge. It stays HIGH until synchronized valid is seen HIGH.
- R5: Synchronized valid may be HIGH while `vec_ack` is HIGH. Then on that edge `vec_ack` falls and `target_ready` pulses for one cycle. `target_addr` becomes `{vec_addr, 2'b00}`.
- R6: After `vec_ack` falls, the block stays busy until synchronized valid is LOW. Entry starts arriving while it is busy (acknowledge or release phase) are ignored and produce no strobe.
- R7: The block may be idle with `vec_port_en` LOW when an IRQ entry starts. Then `target_ready` pulses on the next edge and `vec_ack` is not raised. `target_addr` is 0x00000018, or 0xFFFF0018 when `high_vectors` is HIGH.
- R8: When the block is idle, an FIQ entry produces a strobe on the next edge with `target_addr` 0x0000001C, or 0xFFFF001C when `high_vectors` is HIGH. It never raises `vec_ack`, and it wins over an IRQ entry started in the same cycle.
- R9: Deasserting `irq_req_n` during the handshake does not abort it. The captured address is still delivered and `vec_ack` still falls.
- R10: During and right after reset, `vec_ack`, `target_ready`, both pending outputs and `target_addr` are zero. `target_addr` keeps its last delivered value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiq_req_n | input | 1 | Fast interrupt request, active LOW |
| irq_req_n | input | 1 | Normal interrupt request, active LOW |
| req_sync_bypass | input | 1 | HIGH: request synchronizers bypassed |
| vld_sync_bypass | input | 1 | HIGH: valid synchronizer bypassed |
| high_vectors | input | 1 | HIGH: fixed vectors in the 0xFFFF0000 page |
| vec_port_en | input | 1 | HIGH: IRQ target fetched from the controller |
| irq_entry_start | input | 1 | Core begins IRQ entry (one-cycle pulse) |
| fiq_entry_start | input | 1 | Core begins FIQ entry (one-cycle pulse) |
| vec_ack | output | 1 | Acknowledge to controller, active HIGH |
| vec_valid | input | 1 | Vector address valid, active HIGH |
| vec_addr | input | 30 | Handler address bits [31:2] |
| fiq_pending | output | 1 | Synchronized fast request, active HIGH |
| irq_pending | output | 1 | Synchronized normal request, active HIGH |
| target_ready | output | 1 | One-cycle strobe: target valid |
| target_addr | output | 32 | Branch target for the entry |

## Verification
The hardest cases to reach are entry starts and request withdrawal that arrive in the middle of a handshake. The same applies to the release phase, where acknowledge is already LOW but valid is still HIGH, in particular when valid passes through two synchronizer stages. The stimulus includes a small controller model. It waits for the acknowledge, waits a programmable lag before raising valid, and holds valid for extra cycles after the acknowledge drops. While this model is busy, the stimulus injects fresh entry starts and releases the request line. It repeats this with the valid synchronizer in and out of the path, so every phase sees both early and late valid edges.

// File: rtl/irq_vector_port.sv
module irq_vector_port #(
  parameter int VADDR_W = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fiq_req_n,
  input  logic               irq_req_n,
  input  logic               req_sync_bypass,
  input  logic               vld_sync_bypass,
  input  logic               high_vectors,
  input  logic               vec_port_en,
  input  logic               irq_entry_start,
  input  logic               fiq_entry_start,
  output logic               vec_ack,
  input  logic               vec_valid,
  input  logic [VADDR_W-1:0] vec_addr,
  output logic               fiq_pending,
  output logic               irq_pending,
  output logic               target_ready,
  output logic [31:0]        target_addr
);

  localparam int TGT_W = VADDR_W + 2;
  localparam logic [31:0] IRQ_LO = 32'h0000_0018;
  localparam logic [31:0] IRQ_HI = 32'hFFFF_0018;
  localparam logic [31:0] FIQ_LO = 32'h0000_001C;
  localparam logic [31:0] FIQ_HI = 32'hFFFF_001C;

  typedef enum logic [1:0] {IDLE = 2'd0, ACKING = 2'd1, RELEASE = 2'd2} hs_t;
  hs_t state;

  logic [1:0] fiq_sq, irq_sq, vld_sq;
  logic       valid_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_sq <= 2'b11;
      irq_sq <= 2'b11;
      vld_sq <= 2'b00;
    end else begin
      fiq_sq <= {fiq_sq[0], fiq_req_n};
      irq_sq <= {irq_sq[0], irq_req_n};
      vld_sq <= {vld_sq[0], vec_valid};
    end
  end

  assign fiq_pending = ~(req_sync_bypass ? fiq_req_n : fiq_sq[1]);
  assign irq_pending = ~(req_sync_bypass ? irq_req_n : irq_sq[1]);
  assign valid_s     = vld_sync_bypass ? vec_valid : vld_sq[1];
  assign vec_ack     = (state == ACKING);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= IDLE;
      target_ready <= 1'b0;
      target_addr  <= '0;
    end else begin
      target_ready <= 1'b0;
      unique case (state)
        IDLE: begin
          if (fiq_entry_start) begin
            target_ready <= 1'b1;
            target_addr  <= high_vectors ? FIQ_HI : FIQ_LO;
          end else if (irq_entry_start) begin
            if (vec_port_en) begin
              state <= ACKING;
            end else begin
              target_ready <= 1'b1;
              target_addr  <= high_vectors ? IRQ_HI : IRQ_LO;
            end
          end
        end
        ACKING: begin
          if (valid_s) begin
            target_ready <= 1'b1;
            target_addr  <= 32'({vec_addr, 2'b00});
            state        <= RELEASE;
          end
        end
        RELEASE: begin
          if (!valid_s) state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  logic unused_w;
  assign unused_w = (TGT_W == 0);

endmodule

// File: rtl/irq_vector_port_chk.sv
module irq_vector_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_entry_start,
  input logic        fiq_entry_start,
  input logic        vec_port_en,
  input logic        high_vectors,
  input logic        vec_ack,
  input logic        valid_s,
  input logic        target_ready,
  input logic [1:0]  st,
  input logic [31:0] target_addr,
  input logic [29:0] vec_addr
);

  assert_ack_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && irq_entry_start && !fiq_entry_start && vec_port_en) |=> (vec_ack && !target_ready));

  assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && !valid_s) |=> vec_ack);

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && valid_s) |=> (!vec_ack && target_ready && target_addr == {$past(vec_addr), 2'b00}));

  assert_release_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && valid_s) |=> (!vec_ack && !target_ready));

  assert_legacy_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && irq_entry_start && !fiq_entry_start && !vec_port_en) |=>
      (!vec_ack && target_ready && target_addr == ($past(high_vectors) ? 32'hFFFF_0018 : 32'h0000_0018)));

  assert_fiq_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && fiq_entry_start) |=>
      (!vec_ack && target_ready && target_addr == ($past(high_vectors) ? 32'hFFFF_001C : 32'h0000_001C)));

endmodule

bind irq_vector_port irq_vector_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq_entry_start(irq_entry_start),
  .fiq_entry_start(fiq_entry_start), .vec_port_en(vec_port_en),
  .high_vectors(high_vectors), .vec_ack(vec_ack), .valid_s(valid_s),
  .target_ready(target_ready), .st(state), .target_addr(target_addr),
  .vec_addr(vec_addr)
);

// File: tb/irq_vector_port_tb.sv
module irq_vector_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fiq_req_n = 1'b1, irq_req_n = 1'b1;
  logic req_sync_bypass = 1'b0, vld_sync_bypass = 1'b0;
  logic high_vectors = 1'b0, vec_port_en = 1'b0;
  logic irq_entry_start = 1'b0, fiq_entry_start = 1'b0;
  logic vec_valid = 1'b0;
  logic [29:0] vec_addr = '0;
  logic vec_ack, fiq_pending, irq_pending, target_ready;
  logic [31:0] target_addr;

  always #5 clk = ~clk;

  irq_vector_port dut_i (
    .clk(clk), .rst_n(rst_n), .fiq_req_n(fiq_req_n), .irq_req_n(irq_req_n),
    .req_sync_bypass(req_sync_bypass), .vld_sync_bypass(vld_sync_bypass),
    .high_vectors(high_vectors), .vec_port_en(vec_port_en),
    .irq_entry_start(irq_entry_start), .fiq_entry_start(fiq_entry_start),
    .vec_ack(vec_ack), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .fiq_pending(fiq_pending), .irq_pending(irq_pending),
    .target_ready(target_ready), .target_addr(target_addr)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;

  // behavioural reference: histories as queues, phase as an integer
  bit fq[$] = '{1'b1, 1'b1};
  bit iq[$] = '{1'b1, 1'b1};
  bit vq[$] = '{1'b0, 1'b0};
  int m_phase = 0;
  bit m_ready = 0;
  logic [31:0] m_addr = '0;
  string m_tag = "R10";

  always @(posedge clk) begin
    bit vs;
    if (!rst_n) begin
      fq = '{1'b1, 1'b1}; iq = '{1'b1, 1'b1}; vq = '{1'b0, 1'b0};
      m_phase = 0; m_ready = 0; m_addr = '0; m_tag = "R10";
    end else begin
      vs = vld_sync_bypass ? vec_valid : vq[1];
      m_ready = 0;
      if (m_phase == 0) begin
        if (fiq_entry_start) begin
          m_ready = 1; m_tag = "R8";
          m_addr = high_vectors ? 32'hFFFF001C : 32'h1C;
        end else if (irq_entry_start) begin
          if (vec_port_en) m_phase = 1;
          else begin
            m_ready = 1; m_tag = "R7";
            m_addr = high_vectors ? 32'hFFFF0018 : 32'h18;
          end
        end
      end else if (m_phase == 1) begin
        if (vs) begin
          m_ready = 1; m_tag = "R5"; m_addr = {vec_addr, 2'b00}; m_phase = 2;
        end
      end else if (!vs) m_phase = 0;
      fq.push_front(fiq_req_n); void'(fq.pop_back());
      iq.push_front(irq_req_n); void'(iq.pop_back());
      vq.push_front(vec_valid); void'(vq.pop_back());
    end
  end

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // R1 R2: pending outputs; R4 R6 R3: ack timing; R5 R7 R8: strobe and target
  always @(negedge clk) if (!done) begin
    cmp("R2", "fiq_pending", 32'(fiq_pending),
        32'(req_sync_bypass ? !fiq_req_n : !fq[1]));
    cmp("R2", "irq_pending", 32'(irq_pending),
        32'(req_sync_bypass ? !irq_req_n : !iq[1]));
    cmp(m_phase == 2 ? "R6" : "R4", "vec_ack", 32'(vec_ack), 32'(m_phase == 1));
    cmp(m_tag, "target_ready", 32'(target_ready), 32'(m_ready));
    cmp(m_tag, "target_addr", target_addr, m_addr);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1; mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_irq();
    irq_entry_start = 1; tick(1); irq_entry_start = 0;
  endtask

  // R9: optional withdraw of irq_req_n mid-handshake; R6: optional pokes while busy
  task automatic handshake(logic [29:0] a, bit vbyp, int lag, bit withdraw, bit poke);
    vld_sync_bypass = vbyp; vec_port_en = 1; irq_req_n = 0;
    pulse_irq();
    while (vec_ack !== 1'b1) tick(1);
    if (poke) pulse_irq();
    if (withdraw) irq_req_n = 1;
    tick(lag);
    vec_addr = a; vec_valid = 1;
    while (vec_ack !== 1'b0) tick(1);
    if (poke) pulse_irq();
    tick(2);
    vec_valid = 0; vec_addr = ~a;
    tick(4);
    irq_req_n = 1; vec_port_en = 0;
    tick(2);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    cmp("R10", "reset outputs", {28'd0, vec_ack, target_ready, fiq_pending, irq_pending}, 32'd0);
    cmp("R10", "reset target", target_addr, 32'd0);
    tick(1);
    // R1 R2: synchronized requests
    fiq_req_n = 0; tick(4); irq_req_n = 0; tick(4);
    fiq_req_n = 1; tick(3); irq_req_n = 1; tick(3);
    // R2: bypassed requests
    req_sync_bypass = 1;
    for (int i = 0; i < 6; i++) begin
      fiq_req_n = i[0]; irq_req_n = i[1]; tick(1);
    end
    fiq_req_n = 1; irq_req_n = 1; tick(1);
    req_sync_bypass = 0; tick(3);
    // R7: legacy IRQ vectors
    pulse_irq(); tick(2);
    high_vectors = 1; pulse_irq(); tick(2);
    // R8: fixed FIQ vectors and priority over IRQ
    fiq_entry_start = 1; tick(1); fiq_entry_start = 0; tick(2);
    high_vectors = 0;
    fiq_entry_start = 1; tick(1); fiq_entry_start = 0; tick(2);
    vec_port_en = 1;
    fiq_entry_start = 1; irq_entry_start = 1; tick(1);
    fiq_entry_start = 0; irq_entry_start = 0; tick(3);
    vec_port_en = 0;
    // R4 R5 R3: handshake with synchronized valid
    handshake(30'h00ABCDE1, 0, 3, 0, 0);
    // R3: bypassed valid, R6 pokes while busy
    handshake(30'h3FFFFFFF, 1, 0, 0, 1);
    // R9: withdrawal during handshake
    handshake(30'h01234567, 0, 0, 1, 1);
    handshake(30'h15555555, 1, 5, 1, 0);
    // legacy after port use, high vectors
    high_vectors = 1; pulse_irq(); tick(3);
    @(negedge clk);
    #1 done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule